// File: doc/BRIEF.md
# Bit-Serial Adder

This block adds two unsigned WIDTH-bit numbers one bit position per clock, starting at the least significant bit. A load pulse copies both operands into shift registers. Each clock in which the run input is high then presents one bit of each operand to a carry state machine and shifts the resulting sum bit into a result register. The carry flip-flop is the only state carried from one bit position to the next, so the width of the operands sets only the length of the shift registers and the step counter.

Parameter `REG_SUM` chooses how the sum bit is produced. With `REG_SUM = 0` the sum bit is combinational from the current operand bits and the carry. This form finishes in WIDTH steps. With `REG_SUM = 1` a second flip-flop holds the sum bit, so each sum bit leaves one clock later. This form takes WIDTH+1 steps, and the first bit it shifts in is pushed out of the result register. When the count is reached, `done` rises, shifting stops, and the final carry appears on `carry_out`.

Top module: `bit_serial_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block clears `sum`, `done` and `carry_out` to 0. The reset is synchronous and active high.
- R2: A cycle with `load` high captures `op_a` and `op_b`, clears `sum` to 0, clears the carry state and clears `done`. The effect is visible after that edge.
- R3: With `REG_SUM = 0` and `run` held high, `done` is 1 after WIDTH steps. At that point `sum` equals (`op_a` + `op_b`) mod 2^WIDTH and `carry_out` equals bit WIDTH of the full sum.
- R4: With `REG_SUM = 1` and `run` held high, `done` is 1 after WIDTH+1 steps, with the same `sum` and `carry_out` values as in R3.
- R5: `done` stays 0 until the last step of R3 or R4 has been taken. It is not set one step earlier.
- R6: A cycle with `run` low and `load` low changes neither `sum` nor `done`. Pausing in the middle of an addition does not change its final result.
- R7: Once `done` is 1, further cycles with `run` high leave `sum`, `carry_out` and `done` unchanged until the next load.
- R8: `carry_out` is 0 whenever `done` is 0.
- R9: When `load` and `run` are both high in the same cycle, the load wins: no step is taken, and the new operands are added from their first bit.
- R10: The carry state becomes 1 only after a step whose two operand bits were both 1. It becomes 0 only after a step whose two operand bits were both 0, or after a load. For example, all-ones plus one gives `sum` 0 and `carry_out` 1.
- R11: The result register shifts right and takes each new bit at bit WIDTH-1. With `REG_SUM = 0`, after one step `sum[WIDTH-1]` holds sum bit 0. With `REG_SUM = 1`, after one step `sum` is still 0, and after two steps `sum[WIDTH-1]` holds sum bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture operands and restart the addition |
| op_a | input | WIDTH | First operand, parallel |
| op_b | input | WIDTH | Second operand, parallel |
| run | input | 1 | Take one bit step this cycle |
| sum | output | WIDTH | Result shift register, parallel view |
| carry_out | output | 1 | Final carry, valid while done is high |
| done | output | 1 | All steps for the current operands taken |

## Verification
Both forms are instantiated side by side and driven with the same inputs, so each check compares step counts and the position of the first sum bit between them. A design that counted one step too few in the registered form would lose the top result bit. A design that did not discard the leading bit would shift the whole result one place. The all-ones-plus-one case drives the carry through every position, and a wrong hold condition in the carry would show up as a sum that is not zero. Pauses in the middle of an addition, extra run cycles after completion, and a load that arrives together with run each target the enable and priority logic, where a slip corrupts the result or lets it drift after `done`.

// File: rtl/bit_serial_adder.sv
module bit_serial_adder #(
  parameter int WIDTH   = 8,
  parameter bit REG_SUM = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             run,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             done
);

  localparam int STEPS = WIDTH + (REG_SUM ? 1 : 0);
  localparam int CW    = $clog2(STEPS + 1);

  logic [WIDTH-1:0] sh_a, sh_b, sh_s;
  logic [CW-1:0]    cnt;
  logic             fin;
  logic             carry_q;
  logic             carry_d;
  logic             s_bit;
  logic             cout_src;
  logic             adv;
  logic             bit_a, bit_b;

  assign bit_a   = sh_a[0];
  assign bit_b   = sh_b[0];
  assign adv     = run & ~fin & ~load;
  assign carry_d = (bit_a & bit_b) | (bit_a & carry_q) | (bit_b & carry_q);

  always_ff @(posedge clk) begin
    if (rst || load) carry_q <= 1'b0;
    else if (adv)    carry_q <= carry_d;
  end

  generate
    if (REG_SUM) begin : g_registered
      logic sum_q;
      always_ff @(posedge clk) begin
        if (rst || load) sum_q <= 1'b0;
        else if (adv)    sum_q <= bit_a ^ bit_b ^ carry_q;
      end
      assign s_bit    = sum_q;
      assign cout_src = sum_q;
    end else begin : g_comb
      assign s_bit    = bit_a ^ bit_b ^ carry_q;
      assign cout_src = carry_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_a <= '0;
      sh_b <= '0;
      sh_s <= '0;
      cnt  <= '0;
      fin  <= 1'b0;
    end else if (load) begin
      sh_a <= op_a;
      sh_b <= op_b;
      sh_s <= '0;
      cnt  <= '0;
      fin  <= 1'b0;
    end else if (adv) begin
      sh_a <= {1'b0, sh_a[WIDTH-1:1]};
      sh_b <= {1'b0, sh_b[WIDTH-1:1]};
      sh_s <= {s_bit, sh_s[WIDTH-1:1]};
      cnt  <= cnt + 1'b1;
      fin  <= (cnt == CW'(STEPS - 1));
    end
  end

  assign sum       = sh_s;
  assign done      = fin;
  assign carry_out = fin & cout_src;

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    load |=> (sum == '0) && !done); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!load && !run) |=> $stable(sum) && $stable(done)); // R6
  AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (done && !load) |=> done && $stable(sum) && $stable(carry_out)); // R7
  AST_COUT_GATED: assert property (@(posedge clk) disable iff (rst)
    !done |-> !carry_out); // R8
  AST_CARRY_SETS: assert property (@(posedge clk) disable iff (rst)
    $rose(carry_q) |-> $past(bit_a & bit_b)); // R10
  AST_CARRY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ($fell(carry_q) && !$past(load)) |-> $past(~bit_a & ~bit_b)); // R10
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    (load && run) |=> !done && (sum == '0)); // R9

endmodule

// File: tb/bit_serial_adder_test.sv
`timescale 1ns/1ps
module bit_serial_adder_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst, load, run;
  logic [W-1:0] op_a, op_b;
  logic [W-1:0] sum_c, sum_r;
  logic cout_c, cout_r, done_c, done_r;
  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bit_serial_adder #(.WIDTH(W), .REG_SUM(1'b0)) uut (
    .clk(clk), .rst(rst), .load(load), .op_a(op_a), .op_b(op_b), .run(run),
    .sum(sum_c), .carry_out(cout_c), .done(done_c));

  bit_serial_adder #(.WIDTH(W), .REG_SUM(1'b1)) uut_reg (
    .clk(clk), .rst(rst), .load(load), .op_a(op_a), .op_b(op_b), .run(run),
    .sum(sum_r), .carry_out(cout_r), .done(done_r));

  function automatic logic [W:0] ref_add(input logic [W-1:0] a, input logic [W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] b);
    op_a = a; op_b = b; load = 1'b1; run = 1'b0;
    tick();
    load = 1'b0;
  endtask

  task automatic steps(input int n);
    run = 1'b1;
    for (int i = 0; i < n; i++) tick();
    run = 1'b0;
  endtask

  task automatic check_result(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] e;
    e = ref_add(a, b);
    chk(sum_c == e[W-1:0], "R3 sum", sum_c, e[W-1:0]);
    chk(cout_c == e[W], "R3 carry", cout_c, e[W]);
    chk(sum_r == e[W-1:0], "R4 sum", sum_r, e[W-1:0]);
    chk(cout_r == e[W], "R4 carry", cout_r, e[W]);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_up();
  end

  initial begin
    logic [W-1:0] ra, rb, held;
    logic [W:0] e;
    int seed_init;
    seed_init = $urandom(32'd4711);
    rst = 1'b1; load = 1'b0; run = 1'b0; op_a = '0; op_b = '0;
    tick(); tick();
    chk(sum_c == 0 && done_c == 0 && cout_c == 0, "R1 plain form", {sum_c, done_c, cout_c}, 0);
    chk(sum_r == 0 && done_r == 0 && cout_r == 0, "R1 registered form", {sum_r, done_r, cout_r}, 0);
    rst = 1'b0;

    // R2, R11, R6: first bit position and pause
    do_load(8'h01, 8'h00);
    chk(sum_c == 0 && !done_c && sum_r == 0 && !done_r, "R2 after load", {sum_c, sum_r}, 0);
    steps(1);
    chk(sum_c == 8'h80, "R11 plain first bit", sum_c, 8'h80);
    chk(sum_r == 8'h00, "R11 registered first bit discarded", sum_r, 8'h00);
    steps(1);
    chk(sum_r == 8'h80, "R11 registered bit0 one step later", sum_r, 8'h80);
    held = sum_c;
    tick(); tick(); tick();
    chk(sum_c == held && !done_c, "R6 pause holds", sum_c, held);
    steps(W - 1);
    check_result(8'h01, 8'h00);

    // R5: done timing
    do_load(8'h5A, 8'h3C);
    steps(W - 1);
    chk(!done_c && !done_r, "R5 not early", {done_c, done_r}, 0);
    steps(1);
    chk(done_c == 1'b1, "R5 plain done after WIDTH", done_c, 1);
    chk(done_r == 1'b0, "R5 registered not yet", done_r, 0);
    steps(1);
    chk(done_r == 1'b1, "R5 registered done after WIDTH+1", done_r, 1);
    check_result(8'h5A, 8'h3C);

    // R10, R8: carry through every position
    do_load(8'hFF, 8'h01);
    steps(3);
    chk(cout_c == 0 && cout_r == 0, "R8 carry hidden before done", {cout_c, cout_r}, 0);
    steps(W - 2);
    chk(sum_c == 8'h00 && cout_c == 1'b1, "R10 all-ones plus one plain", {cout_c, sum_c}, 9'h100);
    chk(sum_r == 8'h00 && cout_r == 1'b1, "R10 all-ones plus one registered", {cout_r, sum_r}, 9'h100);

    // R7: extra run cycles after done
    steps(4);
    chk(sum_c == 8'h00 && cout_c && done_c, "R7 plain frozen", {done_c, cout_c, sum_c}, 10'h300);
    chk(sum_r == 8'h00 && cout_r && done_r, "R7 registered frozen", {done_r, cout_r, sum_r}, 10'h300);

    // R9: load together with run
    do_load(8'h11, 8'h22);
    steps(3);
    op_a = 8'hC3; op_b = 8'h7E; load = 1'b1; run = 1'b1;
    tick();
    load = 1'b0;
    chk(sum_c == 0 && !done_c && sum_r == 0, "R9 load wins over run", {sum_c, sum_r}, 0);
    steps(W + 1);
    check_result(8'hC3, 8'h7E);

    // R3/R4 random operands, some with pauses
    for (int k = 0; k < 40; k++) begin
      ra = W'($urandom);
      rb = W'($urandom);
      do_load(ra, rb);
      if (k % 4 == 0) begin
        steps(3);
        tick(); tick();
        steps(W - 2);
      end else begin
        steps(W + 1);
      end
      e = ref_add(ra, rb);
      check_result(ra, rb);
    end

    // R1: reset after completion
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk(sum_c == 0 && !done_c && !cout_c && sum_r == 0 && !done_r, "R1 reset after run",
        {sum_c, sum_r}, 0);
    finish_up();
  end
endmodule